// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit with Flag Generation

This unit takes one operand of a general-purpose shift or rotate and returns the shifted value, a destination write enable, the six arithmetic status flags and a mask telling which of those flags the operation updates. Seven operation kinds are supported: plain rotates left and right, rotates left and right through the carry (a 65-bit loop made of the operand and the incoming carry), a logical left shift, a logical right shift and an arithmetic right shift. The shift amount is chosen by a small select code: the low six bits of an immediate byte, the fixed amount one, or the low six bits of a count register.

A surrounding core merges the flag outputs into its flags register under the mask and writes the result back only when the write enable is high. A shift amount that masks to zero makes the operation a no-op: no write and no flag change.

Operations enter on a valid/ready stream and come out one cycle later from a single output register. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new operation is taken.

Top module: `shrot_unit`

## Requirements
- R1: The shift amount comes from `cnt_sel`. A value of 0 selects `imm[5:0]`, 1 selects the constant 1 (ignoring `imm` and `cnt_reg`), and 2 or 3 selects `cnt_reg[5:0]`. The upper two bits of the selected byte are always discarded.
- R2: When the selected amount is 0, the output has `res_we`=0 and `flag_mask`=0, all flag outputs are 0, and `result` equals the operand.
- R3: With `op`=0 (rotate left), result bits wrap from bit 63 into bit 0. CF is result bit 0 and OF is CF XOR result bit 63. Only C and O are in the mask.
- R4: With `op`=1 (rotate right), result bits wrap from bit 0 into bit 63 and CF is result bit 63. O is in the mask only for an amount of 1, and then OF is operand bit 63 XOR result bit 63.
- R5: With `op`=2 (rotate left through carry), the amount n rotates the 65-bit value {carry_in, operand} left. The new CF is operand bit 64−n, OF is new CF XOR result bit 63, and the mask holds C and O.
- R6: With `op`=3 (rotate right through carry), the 65-bit value rotates right. The new CF is operand bit n−1. O is in the mask only for an amount of 1, and then OF is operand bit 63 XOR result bit 63.
- R7: With `op`=4 or `op`=7 (left shift), zeros enter at the bottom. CF is operand bit 64−n and OF is result bit 63 XOR CF.
- R8: With `op`=5 (logical right shift), zeros fill the top and OF is operand bit 63. With `op`=6 (arithmetic right shift), copies of operand bit 63 fill the top and OF is 0. For both, CF is operand bit n−1.
- R9: Every nonzero-amount shift (op 4 to 7) sets all mask bits. For these shifts, SF is result bit 63, ZF is 1 when the result is zero, PF is 1 when the result's low byte has an even number of ones, and AF is 0. The mask bit order is [5]=O, [4]=S, [3]=Z, [2]=A, [1]=P, [0]=C. A flag output whose mask bit is 0 reads 0.
- R10: The output is registered one cycle after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low. An operation offered during such a stall is taken in the cycle the output drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| op | input | 3 | Operation code (see R3 to R8) |
| cnt_sel | input | 2 | Shift amount source (see R1) |
| operand | input | 64 | Value to shift |
| carry_in | input | 1 | Current carry flag |
| imm | input | 8 | Immediate amount byte |
| cnt_reg | input | 8 | Count register byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Shifted value |
| res_we | output | 1 | Destination should be written |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Adjust flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| flag_mask | output | 6 | Flags written by this operation |

## Verification
Some properties are checked on every cycle by the assertions. These cover the frozen output during a stall, acceptance leading to a valid output, the pairing of a missing write with an empty mask, and the ZF, SF and AF rules whenever those bits are in the mask. The bit-level results cannot be checked that way. This includes wraparound for each rotate kind, the carry taken from the right operand bit, the fill for arithmetic versus logical shifts, the count-source decode with its six-bit masking, and the amount-of-one special case for OF. Only the bench's vectors show these, with expected values worked out by hand, along with the stall-then-release sequence.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_SAL = 3'd7
  } shop_e;

  localparam int NFLAGS = 6;
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  typedef logic [NFLAGS-1:0] flagvec_t;
endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int W  = 64,
  parameter int BW = 8,
  localparam int CW = $clog2(W)
) (
  input  logic [1:0]    sel,
  input  logic [BW-1:0] imm,
  input  logic [BW-1:0] creg,
  output logic [CW-1:0] amount
);
  always_comb begin
    unique case (sel)
      2'd0:    amount = imm[CW-1:0];
      2'd1:    amount = CW'(1);
      default: amount = creg[CW-1:0];
    endcase
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [2:0]    op,
  input  logic [CW-1:0] amount,
  input  logic [W-1:0]  x,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          we,
  output flagvec_t      flags,
  output flagvec_t      mask
);
  // doubled copies turn a rotate into a plain shift plus a slice
  logic [2*W-1:0]      rol_w, ror_w;
  logic [2*W+1:0]      rcl_w, rcr_w;
  logic [W:0]          shl_w, shr_w;
  logic signed [W:0]   sar_w;

  assign rol_w = {x, x} << amount;
  assign ror_w = {x, x} >> amount;
  assign rcl_w = {cin, x, cin, x} << amount;
  assign rcr_w = {cin, x, cin, x} >> amount;
  assign shl_w = {1'b0, x} << amount;
  assign shr_w = {x, 1'b0} >> amount;
  assign sar_w = $signed({x, 1'b0}) >>> amount;

  logic     by_one;
  logic [W-1:0] r;
  logic     c, o;
  flagvec_t m;
  flagvec_t raw;

  assign by_one = (amount == CW'(1));

  always_comb begin
    r = x;
    c = 1'b0;
    o = 1'b0;
    m = '0;
    unique case (shop_e'(op))
      OP_ROL: begin
        r = rol_w[2*W-1:W];
        c = r[0];
        o = c ^ r[W-1];
        m[FL_C] = 1'b1;
        m[FL_O] = 1'b1;
      end
      OP_ROR: begin
        r = ror_w[W-1:0];
        c = r[W-1];
        o = x[W-1] ^ r[W-1];
        m[FL_C] = 1'b1;
        m[FL_O] = by_one;
      end
      OP_RCL: begin
        r = rcl_w[2*W:W+1];
        c = rcl_w[2*W+1];
        o = c ^ r[W-1];
        m[FL_C] = 1'b1;
        m[FL_O] = 1'b1;
      end
      OP_RCR: begin
        r = rcr_w[W-1:0];
        c = rcr_w[W];
        o = x[W-1] ^ r[W-1];
        m[FL_C] = 1'b1;
        m[FL_O] = by_one;
      end
      OP_SHL, OP_SAL: begin
        r = shl_w[W-1:0];
        c = shl_w[W];
        o = r[W-1] ^ c;
        m = '1;
      end
      OP_SHR: begin
        r = shr_w[W:1];
        c = shr_w[0];
        o = x[W-1];
        m = '1;
      end
      default: begin // OP_SAR
        r = sar_w[W:1];
        c = sar_w[0];
        o = 1'b0;
        m = '1;
      end
    endcase
  end

  always_comb begin
    raw        = '0;
    raw[FL_C]  = c;
    raw[FL_O]  = o;
    raw[FL_S]  = r[W-1];
    raw[FL_Z]  = (r == '0);
    raw[FL_P]  = ~^r[7:0];
    raw[FL_A]  = 1'b0;
  end

  always_comb begin
    if (amount == '0) begin
      res   = x;
      we    = 1'b0;
      mask  = '0;
      flags = '0;
    end else begin
      res   = r;
      we    = 1'b1;
      mask  = m;
      flags = raw & m;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W  = 64,
  parameter int BW = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic [1:0]    cnt_sel,
  input  logic [W-1:0]  operand,
  input  logic          carry_in,
  input  logic [BW-1:0] imm,
  input  logic [BW-1:0] cnt_reg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result,
  output logic          res_we,
  output logic          cf_o,
  output logic          pf_o,
  output logic          af_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          of_o,
  output logic [NFLAGS-1:0] flag_mask
);
  logic [CW-1:0] amount;
  logic [W-1:0]  c_res;
  logic          c_we;
  flagvec_t      c_flags, c_mask;

  shrot_count #(.W(W), .BW(BW)) u_count (
    .sel    (cnt_sel),
    .imm    (imm),
    .creg   (cnt_reg),
    .amount (amount)
  );

  shrot_core #(.W(W)) u_core (
    .op     (op),
    .amount (amount),
    .x      (operand),
    .cin    (carry_in),
    .res    (c_res),
    .we     (c_we),
    .flags  (c_flags),
    .mask   (c_mask)
  );

  logic          vld_q;
  logic [W-1:0]  res_q;
  logic          we_q;
  flagvec_t      flags_q, mask_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
      mask_q  <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q   <= c_res;
        we_q    <= c_we;
        flags_q <= c_flags;
        mask_q  <= c_mask;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign res_we    = we_q;
  assign flag_mask = mask_q;
  assign cf_o      = flags_q[FL_C];
  assign pf_o      = flags_q[FL_P];
  assign af_o      = flags_q[FL_A];
  assign zf_o      = flags_q[FL_Z];
  assign sf_o      = flags_q[FL_S];
  assign of_o      = flags_q[FL_O];

  // R10: stalled output is frozen
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(res_we)
                                   && $stable(flag_mask) && $stable(cf_o) && $stable(of_o)));

  // R10: an accepted operation appears on the next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2: no destination write means no flag written
  a_r2_no_write_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_we) |-> (flag_mask == '0));

  // R9: zero flag tracks the registered result
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_mask[FL_Z]) |-> (zf_o == (result == '0)));

  // R9: sign flag tracks the top result bit
  a_r9_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_mask[FL_S]) |-> (sf_o == result[W-1]));

  // R9: adjust flag is always cleared, and only shifts write the full set
  a_r9_adjust_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_mask[FL_A]) |-> (!af_o && flag_mask == '1));
endmodule

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sel;
    logic [63:0] x;
    logic        cin;
    logic [7:0]  imm;
    logic [7:0]  creg;
    logic [63:0] eres;
    logic        ewe;
    logic [5:0]  emask; // O S Z A P C
    logic [5:0]  eflg;  // O S Z A P C
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R3 rotate left by imm 4
    '{3'd0, 2'd0, 64'h8000_0000_0000_0001, 1'b0, 8'h04, 8'h00, 64'h0000_0000_0000_0018, 1'b1, 6'b100001, 6'b000000},
    // R4 R1 rotate right by constant one, imm ignored
    '{3'd1, 2'd1, 64'h0000_0000_0000_0001, 1'b0, 8'h55, 8'h22, 64'h8000_0000_0000_0000, 1'b1, 6'b100001, 6'b100001},
    // R4 rotate right by 8, no OF
    '{3'd1, 2'd0, 64'h0000_0000_0000_00FF, 1'b0, 8'h08, 8'h00, 64'hFF00_0000_0000_0000, 1'b1, 6'b000001, 6'b000001},
    // R5 through carry left by one
    '{3'd2, 2'd1, 64'h8000_0000_0000_0000, 1'b1, 8'h00, 8'h00, 64'h0000_0000_0000_0001, 1'b1, 6'b100001, 6'b100001},
    // R5 R1 count register 0x44 masks to 4
    '{3'd2, 2'd2, 64'hF000_0000_0000_0000, 1'b1, 8'h00, 8'h44, 64'h0000_0000_0000_000F, 1'b1, 6'b100001, 6'b100001},
    // R6 through carry right by one
    '{3'd3, 2'd1, 64'h0000_0000_0000_0002, 1'b1, 8'h00, 8'h00, 64'h8000_0000_0000_0001, 1'b1, 6'b100001, 6'b100000},
    // R6 through carry right by 2
    '{3'd3, 2'd0, 64'h0000_0000_0000_0003, 1'b0, 8'h02, 8'h00, 64'h8000_0000_0000_0000, 1'b1, 6'b000001, 6'b000001},
    // R7 left shift by one
    '{3'd4, 2'd1, 64'h4000_0000_0000_0000, 1'b0, 8'h00, 8'h00, 64'h8000_0000_0000_0000, 1'b1, 6'b111111, 6'b110010},
    // R2 R1 imm 0x40 masks to zero
    '{3'd4, 2'd0, 64'h0000_0000_0000_1234, 1'b1, 8'h40, 8'h00, 64'h0000_0000_0000_1234, 1'b0, 6'b000000, 6'b000000},
    // R8 logical right by 4
    '{3'd5, 2'd0, 64'h8000_0000_0000_00F8, 1'b0, 8'h04, 8'h00, 64'h0800_0000_0000_000F, 1'b1, 6'b111111, 6'b100011},
    // R8 arithmetic right by 1 from count register
    '{3'd6, 2'd2, 64'h8000_0000_0000_0003, 1'b0, 8'h00, 8'h01, 64'hC000_0000_0000_0001, 1'b1, 6'b111111, 6'b010001},
    // R8 arithmetic right by 63
    '{3'd6, 2'd0, 64'h8000_0000_0000_0000, 1'b0, 8'h3F, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'b111111, 6'b010010},
    // R9 logical right by 63 to zero
    '{3'd5, 2'd0, 64'h4000_0000_0000_0000, 1'b0, 8'hFF, 8'h00, 64'h0000_0000_0000_0000, 1'b1, 6'b111111, 6'b001011},
    // R2 count register 0xC0 masks to zero
    '{3'd0, 2'd2, 64'h0000_0000_0000_ABCD, 1'b0, 8'h07, 8'hC0, 64'h0000_0000_0000_ABCD, 1'b0, 6'b000000, 6'b000000},
    // R1 select 3 reads count register, R7 shift by 63
    '{3'd4, 2'd3, 64'h0000_0000_0000_0001, 1'b0, 8'h01, 8'h3F, 64'h8000_0000_0000_0000, 1'b1, 6'b111111, 6'b110010},
    // R7 op 7 alias, carry out to zero result
    '{3'd7, 2'd1, 64'h8000_0000_0000_0000, 1'b0, 8'h00, 8'h00, 64'h0000_0000_0000_0000, 1'b1, 6'b111111, 6'b101011}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [1:0]  cnt_sel = '0;
  logic [63:0] operand = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  imm = '0;
  logic [7:0]  cnt_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        res_we;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;
  logic [5:0]  flag_mask;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shrot_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .cnt_sel(cnt_sel), .operand(operand), .carry_in(carry_in),
    .imm(imm), .cnt_reg(cnt_reg), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .res_we(res_we), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o),
    .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .flag_mask(flag_mask)
  );

  function automatic string tag_of(vec_t v);
    if (!v.ewe) return "R2";
    case (v.op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    op = v.op; cnt_sel = v.sel; operand = v.x; carry_in = v.cin;
    imm = v.imm; cnt_reg = v.creg;
  endtask

  task automatic check_out(vec_t v, string tag);
    check(tag, "out_valid", 64'(out_valid), 64'd1);
    check(tag, "result", result, v.eres);
    check(tag, "res_we", 64'(res_we), 64'(v.ewe));
    check(tag, "flag_mask R9", 64'(flag_mask), 64'(v.emask));
    check(tag, "flags R9", 64'({of_o, sf_o, zf_o, af_o, pf_o, cf_o}), 64'(v.eflg));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset out_valid", 64'(out_valid), 64'd0);
    check("R10", "reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_out(VEC[i], tag_of(VEC[i]));
    end
    @(negedge clk);
    check("R10", "drained", 64'(out_valid), 64'd0);

    // R10 stall: hold output, refuse new operation, take it on release
    out_ready = 1'b0;
    drive(VEC[7]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[9]);
    check("R10", "in_ready during stall", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    check_out(VEC[7], "R10");
    check("R10", "in_ready still low", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(VEC[9], "R10");
    @(negedge clk);
    check("R10", "empty after drain", 64'(out_valid), 64'd0);

    finish_run();
  end
endmodule